// File: doc/BRIEF.md
# Peripheral Clock-Enable Power Controller

This block decides, every cycle, whether each of four peripheral modules receives its clock. Its output is one clock-enable bit per module, which stands in for the module's gated oscillator. Two powerdown styles are available to each module. Direct powerdown is a software bit that stops the clock at once, whatever the module is doing, and it stays in force until software clears it or a reset occurs. Auto powerdown is qualified by idleness. While it is enabled, the module sleeps as soon as its idle indication has been seen on a clock edge. It wakes in the very cycle an activity event appears, or in the cycle a configuration read or write targets it.

A global clock-off bit sits above both styles and stops every module's clock. A separate per-module enable bit turns an unused module fully off, independently of powerdown. Software reaches everything through a plain register port. Writes are strobed by `cfg_wr`. `cfg_rdata` always shows the register selected by `cfg_addr`, and `cfg_rd` marks a read access, which counts as a wake event. The port is control traffic rather than a data stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `pm_ctrl`

## Requirements
- R1: While `hw_rst` is high at a clock edge, every module's direct bit, auto bit and sleep state are cleared, every module enable is set to 1 and clock-off is cleared, so after reset all four `mod_clk_en` bits are 1 and each module register reads 0x04.
- R2: Writing a module register with bit 0 (direct powerdown) set drives that module's `mod_clk_en` low from the next cycle on, regardless of its idle and activity inputs.
- R3: Writing bit 0 back to 0 (with bit 2 kept at 1) restores that module's `mod_clk_en` from the next cycle.
- R4: With bit 1 (auto powerdown enable) set, a clock edge at which the module's `mod_idle` is 1 and no wake event is present puts the module to sleep, and its `mod_clk_en` is 0 from the following cycle. While `mod_idle` is 0, the module does not sleep.
- R5: A `mod_act` pulse makes a sleeping module's `mod_clk_en` 1 in the same cycle and clears the sleep state at that edge. Sleep is re-entered only after `mod_idle` is seen again at a later edge without a wake event.
- R6: A configuration read (`cfg_rd`) or write (`cfg_wr`) addressed to a module counts as a wake event for that module only.
- R7: A write with bit 3 (module reset) set clears that module's direct bit, auto bit and sleep state. It leaves the module enable unchanged and ignores the other written bits. Bit 3 always reads 0.
- R8: The global register at address 4, bit 0 (clock-off), forces every `mod_clk_en` to 0 while it is set, and it changes no per-module register bit.
- R9: Module register bit 2 (module enable) at 0 forces that module's `mod_clk_en` to 0.
- R10: Module register bit 4 reads the module's `mod_idle` input, and bit 5 reads its sleep state. Both are read-only, and writes to them have no effect.
- R11: Module m's register sits at address m (0..3) and the global register at address 4. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (wake event for the addressed module) |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Contents of the addressed register |
| mod_idle | input | 4 | Per-module idle indication |
| mod_act | input | 4 | Per-module activity (wake) pulse |
| mod_clk_en | output | 4 | Per-module gated clock enable |

## Verification
Direct powerdown is applied with activity held high and with idle toggling. This separates an unconditional gate from an idle-qualified one. Auto powerdown is run with idle low, with idle high, with single-cycle activity pulses and with reads aimed at the same module and at a neighbour. Together these show same-cycle wake, wake scoped to one module, and re-entry after one idle edge. The module reset bit, clock-off and the enable bit are each combined with powerdown states already set, which shows the precedence among them and that clock-off leaves the register contents intact.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // Module register field positions
  localparam int F_DPD  = 0;  // direct powerdown, rw
  localparam int F_APD  = 1;  // auto powerdown enable, rw
  localparam int F_EN   = 2;  // module enable, rw
  localparam int F_RST  = 3;  // module reset, write-only strobe
  localparam int F_IDLE = 4;  // idle status, ro
  localparam int F_SLP  = 5;  // asleep status, ro
  localparam int MOD_FIELD_W = F_SLP + 1;
  // Global register field positions
  localparam int G_CLKOFF = 0;

  typedef struct packed {
    logic slp;
    logic en;
    logic apd;
    logic dpd;
  } pm_state_t;
endpackage

// File: rtl/pm_global.sv
module pm_global
  import pm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit_i,
  input  logic              wbit_i,
  output logic              clk_on_o,
  output logic [DATA_W-1:0] stat_o
);
  logic clk_off_q;

  always_ff @(posedge clk) begin
    if (rst)           clk_off_q <= 1'b0;
    else if (wr_hit_i) clk_off_q <= wbit_i;
  end

  assign clk_on_o = ~clk_off_q;

  always_comb begin
    stat_o = '0;
    stat_o[G_CLKOFF] = clk_off_q;
  end
endmodule

// File: rtl/pm_slice.sv
module pm_slice
  import pm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_on_i,
  input  logic              wr_hit_i,
  input  logic              rd_hit_i,
  input  logic [F_RST:0]    wfld_i,
  input  logic              idle_i,
  input  logic              act_i,
  output logic              clk_en_o,
  output logic [DATA_W-1:0] stat_o
);
  pm_state_t st_q;
  logic      wake;

  assign wake = act_i | wr_hit_i | rd_hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '{slp: 1'b0, en: 1'b1, apd: 1'b0, dpd: 1'b0};
    end else begin
      if (wr_hit_i) begin
        if (wfld_i[F_RST]) begin
          st_q.dpd <= 1'b0;
          st_q.apd <= 1'b0;
        end else begin
          st_q.dpd <= wfld_i[F_DPD];
          st_q.apd <= wfld_i[F_APD];
          st_q.en  <= wfld_i[F_EN];
        end
      end
      if (wake)                     st_q.slp <= 1'b0;
      else if (st_q.apd && idle_i)  st_q.slp <= 1'b1;
    end
  end

  // wake overrides a pending sleep within the same cycle
  assign clk_en_o = clk_on_i & st_q.en & ~st_q.dpd & ~(st_q.slp & ~wake);

  always_comb begin
    stat_o = '0;
    stat_o[F_DPD]  = st_q.dpd;
    stat_o[F_APD]  = st_q.apd;
    stat_o[F_EN]   = st_q.en;
    stat_o[F_IDLE] = idle_i;
    stat_o[F_SLP]  = st_q.slp;
  end

  a_r2_direct_gates: assert property (@(posedge clk) disable iff (rst)
    st_q.dpd |-> !clk_en_o);
  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (st_q.apd && idle_i && !wake) |=> (!clk_en_o || act_i || wr_hit_i || rd_hit_i));
  a_r5_wake_clears: assert property (@(posedge clk) disable iff (rst)
    wake |=> !st_q.slp);
  a_r7_reset_bit: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && wfld_i[F_RST]) |=> (!st_q.dpd && !st_q.apd && $stable(st_q.en)));
  a_r9_enable_gates: assert property (@(posedge clk) disable iff (rst)
    !st_q.en |-> !clk_en_o);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = $clog2(NUM_MOD + 1)
) (
  input  logic               clk,
  input  logic               hw_rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [NUM_MOD-1:0] mod_idle,
  input  logic [NUM_MOD-1:0] mod_act,
  output logic [NUM_MOD-1:0] mod_clk_en
);
  localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(NUM_MOD);

  logic              clk_on;
  logic [DATA_W-1:0] glb_stat;
  logic [DATA_W-1:0] mod_stat [NUM_MOD];

  pm_global #(.DATA_W(DATA_W)) u_glb (
    .clk      (clk),
    .rst      (hw_rst),
    .wr_hit_i (cfg_wr && (cfg_addr == GLB_ADDR)),
    .wbit_i   (cfg_wdata[G_CLKOFF]),
    .clk_on_o (clk_on),
    .stat_o   (glb_stat)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    pm_slice #(.DATA_W(DATA_W)) u_slice (
      .clk      (clk),
      .rst      (hw_rst),
      .clk_on_i (clk_on),
      .wr_hit_i (cfg_wr && (cfg_addr == ADDR_W'(g))),
      .rd_hit_i (cfg_rd && (cfg_addr == ADDR_W'(g))),
      .wfld_i   (cfg_wdata[F_RST:0]),
      .idle_i   (mod_idle[g]),
      .act_i    (mod_act[g]),
      .clk_en_o (mod_clk_en[g]),
      .stat_o   (mod_stat[g])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_MOD; i++)
      if (cfg_addr == ADDR_W'(i)) cfg_rdata = mod_stat[i];
    if (cfg_addr == GLB_ADDR) cfg_rdata = glb_stat;
  end

  a_r8_clock_off: assert property (@(posedge clk) disable iff (hw_rst)
    (glb_stat[G_CLKOFF]) |-> (mod_clk_en == '0));
  a_r1_reset_open: assert property (@(posedge clk)
    $past(hw_rst) && !$past(cfg_wr) |-> (mod_clk_en == '1) || hw_rst);
endmodule

// File: tb/test_pm_ctrl.sv
module test_pm_ctrl;
  logic       clk = 1'b0;
  logic       hw_rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] mod_idle = '0, mod_act = '0;
  logic [3:0] mod_clk_en;

  int total = 0, bad = 0;
  string cur_req = "R1";

  // reference model state
  bit m_dpd[4] = '{0,0,0,0};
  bit m_apd[4] = '{0,0,0,0};
  bit m_en[4]  = '{1,1,1,1};
  bit m_slp[4] = '{0,0,0,0};
  bit m_off = 0;

  pm_ctrl i_pm_ctrl (
    .clk(clk), .hw_rst(hw_rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mod_idle(mod_idle), .mod_act(mod_act), .mod_clk_en(mod_clk_en)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic bit wake(int m);
    return mod_act[m] || ((cfg_wr || cfg_rd) && cfg_addr == 3'(m));
  endfunction

  function automatic logic [3:0] exp_en();
    logic [3:0] e;
    for (int m = 0; m < 4; m++)
      e[m] = !m_off && m_en[m] && !m_dpd[m] && !(m_slp[m] && !wake(m));
    return e;
  endfunction

  function automatic logic [7:0] exp_rd();
    int a = int'(cfg_addr);
    if (a < 4) return {2'b00, m_slp[a], mod_idle[a], 1'b0, m_en[a], m_apd[a], m_dpd[a]};
    if (a == 4) return {7'b0, m_off};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (hw_rst) begin
      for (int m = 0; m < 4; m++) begin
        m_dpd[m] = 0; m_apd[m] = 0; m_en[m] = 1; m_slp[m] = 0;
      end
      m_off = 0;
    end else begin
      bit wk[4];
      for (int m = 0; m < 4; m++) wk[m] = wake(m);
      for (int m = 0; m < 4; m++) begin
        if (cfg_wr && cfg_addr == 3'(m)) begin
          if (cfg_wdata[3]) begin m_dpd[m] = 0; m_apd[m] = 0; end
          else begin m_dpd[m] = cfg_wdata[0]; m_apd[m] = cfg_wdata[1]; m_en[m] = cfg_wdata[2]; end
        end
        if (wk[m]) m_slp[m] = 0;
        else if (m_apd[m] && mod_idle[m]) m_slp[m] = 1;
      end
      if (cfg_wr && cfg_addr == 3'd4) m_off = cfg_wdata[0];
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    #1;
    total++;
    if (mod_clk_en !== exp_en()) begin
      bad++;
      $display("FAIL %s mod_clk_en actual=%b expected=%b t=%0t", cur_req, mod_clk_en, exp_en(), $time);
    end
    total++;
    if (cfg_rdata !== exp_rd()) begin
      bad++;
      $display("FAIL %s cfg_rdata actual=%h expected=%h t=%0t", cur_req, cfg_rdata, exp_rd(), $time);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1"; cyc(3); hw_rst = 0; cyc(2);
    rd(3'd0); rd(3'd3);
    // R2: direct powerdown, activity and idle ignored
    cur_req = "R2"; mod_act[1] = 1; wr(3'd1, 8'h05); cyc(3);
    mod_idle[1] = 1; cyc(2); mod_act[1] = 0; mod_idle[1] = 0; cyc(2);
    // R3: clear direct bit
    cur_req = "R3"; wr(3'd1, 8'h04); cyc(3);
    // R4: auto powerdown entry only while idle
    cur_req = "R4"; wr(3'd2, 8'h06); cfg_addr = 3'd2; cyc(4);
    mod_idle[2] = 1; cyc(4);
    // R5: activity wakes same cycle, re-entry after an idle edge
    cur_req = "R5"; mod_act[2] = 1; cyc(1); mod_act[2] = 0; cyc(3);
    mod_idle[2] = 0; mod_act[2] = 1; cyc(1); mod_act[2] = 0; cyc(2); mod_idle[2] = 1; cyc(3);
    // R6: config access wakes only the addressed module
    cur_req = "R6"; rd(3'd0); cyc(1); rd(3'd2); cyc(2); wr(3'd2, 8'h06); cyc(2);
    // R7: module reset bit
    cur_req = "R7"; mod_idle[3] = 1; wr(3'd3, 8'h03); cyc(3); wr(3'd3, 8'h0F); cfg_addr = 3'd3; cyc(3);
    wr(3'd3, 8'h02); cyc(3); wr(3'd3, 8'h08); cfg_addr = 3'd3; cyc(3); mod_idle[3] = 0;
    // R8: global clock-off
    cur_req = "R8"; wr(3'd0, 8'h05); wr(3'd4, 8'h01); cyc(2);
    rd(3'd0); rd(3'd1); rd(3'd2); rd(3'd4); wr(3'd4, 8'h00); cyc(2); wr(3'd0, 8'h04);
    // R9: module enable bit
    cur_req = "R9"; wr(3'd0, 8'h00); cyc(3); wr(3'd0, 8'h04); cyc(2);
    // R10: read-only status bits
    cur_req = "R10"; mod_idle[0] = 1; wr(3'd0, 8'h34); cfg_addr = 3'd0; cyc(2); mod_idle[0] = 0; cyc(2);
    // R11: unmapped addresses
    cur_req = "R11"; wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd5); rd(3'd6); rd(3'd7); rd(3'd1); rd(3'd4);
    // R1: mid-run hardware reset clears powerdown state
    cur_req = "R1"; wr(3'd1, 8'h07); wr(3'd4, 8'h01); hw_rst = 1; cyc(2); hw_rst = 0; cyc(2);
    rd(3'd1); rd(3'd4);
    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule